// File: doc/BRIEF.md
# Selectable-Rate Error Message Flasher

This block blinks a two-letter error message ("Er") on a pair of seven-segment digits at one of four rates. It divides a fast system clock, nominally 27 MHz, with a reloadable down-counter. Each time the counter reaches zero it produces a one-cycle pulse, and that pulse toggles a single display state bit. The state bit picks between the message and blank, so the blink has an equal on-time and off-time.

The two outputs are 7-bit code words that feed segment decoders outside this block. One code word is for the letter E and one is for the letter r. A 2-bit select input sets the blink rate to 1, 2, 4 or 8 Hz. A run enable freezes the blink in whatever state it is in. A parameter divides every divide constant by 1000, so that one millisecond of simulated time stands for one second on hardware.

Top module: `err_flasher`

## Requirements
- R1: While reset is asserted, and after it, until the first toggle, both code outputs carry the blank code 127 (7'b1111111).
- R2: The number of enabled clock cycles in each message or blank half-period is F/2, F/4, F/8 and F/16 for rate_sel values 0, 1, 2 and 3, where F is CLK_HZ, or CLK_HZ/1000 when FAST_SIM is 1. This gives visible blink rates of 1, 2, 4 and 8 Hz.
- R3: The counter reloads with half-period minus 1 when it reaches zero. On the first clock after reset it loads without pulsing. The constant used for a reload is the one for the rate_sel value present at that reload, so a select change takes effect at the next reload.
- R4: Every zero pulse flips the display state exactly once, and the state never changes in any other cycle.
- R5: While run_en is 0, the counter and both outputs hold their values. The display is frozen and is not forced to blank.
- R6: In the message state, e_code is 29 (7'b0011101) and r_code is 14 (7'b0001110). In the blank state, both are 127.
- R7: The two outputs change in the same cycle. One never shows blank while the other shows a letter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rate_sel | input | 2 | Blink rate select: 0=1 Hz, 1=2 Hz, 2=4 Hz, 3=8 Hz |
| run_en | input | 1 | Count enable; 0 freezes the display |
| e_code | output | 7 | Code word for the E digit (29 or 127) |
| r_code | output | 7 | Code word for the r digit (14 or 127) |

## Verification
The embedded assertions check several properties on every cycle:
- the counter stays inside the largest half-period,
- a zero pulse always reloads the constant for the current select value,
- the state bit moves only on a pulse,
- a low enable holds both the counter and the outputs,
- the two outputs never disagree on blank.

Only the bench scenarios can show the remaining behaviour. These scenarios cover the actual half-period length for each select value, and the deferred effect of changing the select in the middle of a period. They also cover a freeze taken while the message is showing, which proves the freeze does not blank. A cycle-level reference model in the bench covers these cases under random enable and select traffic.

// File: rtl/flash_pkg.sv
package flash_pkg;
  localparam logic [6:0] CODE_E     = 7'd29;
  localparam logic [6:0] CODE_R     = 7'd14;
  localparam logic [6:0] CODE_BLANK = 7'h7F;

  // cycles per half blink period; sel 0 is the slowest rate (2 toggles per second)
  function automatic int unsigned half_cycles(input int unsigned clk_hz,
                                              input bit fast,
                                              input int unsigned sel);
    int unsigned base;
    base = fast ? (clk_hz / 1000) : clk_hz;
    return base / (2 << sel);
  endfunction
endpackage

// File: rtl/rate_divider.sv
module rate_divider
  import flash_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 27_000_000,
  parameter bit          FAST_SIM = 1'b0,
  parameter int unsigned SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             run_en,
  output logic             tick
);
  localparam int unsigned NSEL = 1 << SEL_W;
  localparam int unsigned MAXR = half_cycles(CLK_HZ, FAST_SIM, 0) - 1;
  localparam int unsigned CW   = (MAXR < 2) ? 1 : $clog2(MAXR + 1);

  logic [CW-1:0] reload_tab [NSEL];
  logic [CW-1:0] reload_now;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          primed_q, primed_d;
  logic          cnt_en;

  for (genvar i = 0; i < NSEL; i++) begin : g_reload
    assign reload_tab[i] = CW'(half_cycles(CLK_HZ, FAST_SIM, i) - 1);
  end

  assign reload_now = reload_tab[sel];
  assign tick       = primed_q & run_en & (cnt_q == '0);
  assign cnt_en     = ~primed_q | run_en;

  always_comb begin
    cnt_d    = cnt_q;
    primed_d = primed_q;
    if (!primed_q) begin
      cnt_d    = reload_now;
      primed_d = 1'b1;
    end else if (run_en) begin
      cnt_d = (cnt_q == '0) ? reload_now : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      primed_q <= primed_d;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q |-> (cnt_q <= CW'(MAXR))); // R2
  AST_RELOAD_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == $past(reload_now))); // R3
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && !run_en) |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/blink_state.sv
module blink_state (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic show
);
  logic show_q, show_d;

  assign show_d = ~show_q;
  assign show   = show_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    show_q <= 1'b0;
    else if (tick) show_q <= show_d;
  end

  AST_TOGGLE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (show_q != $past(show_q))); // R4
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(show_q)); // R4
endmodule

// File: rtl/code_mux.sv
module code_mux
  import flash_pkg::*;
(
  input  logic       show,
  output logic [6:0] e_code,
  output logic [6:0] r_code
);
  always_comb begin
    if (show) begin
      e_code = CODE_E;
      r_code = CODE_R;
    end else begin
      e_code = CODE_BLANK;
      r_code = CODE_BLANK;
    end
  end
endmodule

// File: rtl/err_flasher.sv
module err_flasher
  import flash_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 27_000_000,
  parameter bit          FAST_SIM = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  input  logic       run_en,
  output logic [6:0] e_code,
  output logic [6:0] r_code
);
  logic tick;
  logic show;

  rate_divider #(.CLK_HZ(CLK_HZ), .FAST_SIM(FAST_SIM), .SEL_W(2)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (rate_sel),
    .run_en (run_en),
    .tick   (tick)
  );

  blink_state u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .show  (show)
  );

  code_mux u_mux (
    .show   (show),
    .e_code (e_code),
    .r_code (r_code)
  );

  AST_PAIR_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    ((e_code == CODE_BLANK) == (r_code == CODE_BLANK))); // R7
  AST_OUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> ($stable(e_code) && $stable(r_code))); // R5
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ((e_code == CODE_E) || (e_code == CODE_BLANK))); // R6
endmodule

// File: tb/sim_err_flasher.sv
module sim_err_flasher;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic       run_en = 1'b0;
  logic [6:0] e_code, r_code;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit chk_on = 1'b0;
  string tag = "R6";

  // 32 scaled cycles per "second": half periods 16, 8, 4, 2 cycles
  err_flasher #(.CLK_HZ(32000), .FAST_SIM(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .run_en(run_en),
    .e_code(e_code), .r_code(r_code)
  );

  always #4 clk = ~clk;

  function automatic int half_per(input logic [1:0] s);
    return 16 >> s;
  endfunction

  // reference model: enabled cycles since last reload versus current period
  bit m_primed, m_show;
  int m_since, m_per;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_primed = 1'b0; m_show = 1'b0; m_since = 0; m_per = 16;
    end else if (!m_primed) begin
      m_primed = 1'b1; m_per = half_per(rate_sel); m_since = 0;
    end else if (run_en) begin
      if (m_since + 1 == m_per) begin
        m_show = ~m_show; m_since = 0; m_per = half_per(rate_sel);
      end else begin
        m_since++;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) begin
      chk(tag, e_code, m_show ? 29 : 127);
      chk(tag, r_code, m_show ? 14 : 127);
      chk("R7", (e_code == 7'h7F) == (r_code == 7'h7F), 1);
    end
  end

  task automatic do_reset();
    @(negedge clk);
    chk_on = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", e_code, 127);
    chk("R1", r_code, 127);
    rst_n = 1'b1;
    chk_on = 1'b1;
  endtask

  task automatic measure(input logic [1:0] s);
    logic [6:0] prev;
    int n;
    tag = "R2";
    rate_sel = s;
    run_en = 1'b1;
    do_reset();
    @(negedge clk);
    chk("R1", e_code, 127);
    prev = e_code;
    while (e_code == prev) @(negedge clk);
    prev = e_code;
    n = 0;
    while (e_code == prev) begin @(negedge clk); n++; end
    chk("R2", n, half_per(s));
    prev = e_code;
    n = 0;
    while (e_code == prev) begin @(negedge clk); n++; end
    chk("R4", n, half_per(s));
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int s = 0; s < 4; s++) measure(2'(s));

    // R6: message codes while showing
    tag = "R6";
    rate_sel = 2'd1; run_en = 1'b1;
    do_reset();
    while (e_code != 7'd29) @(negedge clk);
    chk("R6", e_code, 29);
    chk("R6", r_code, 14);

    // R5: freeze while the message is showing, must not blank
    tag = "R5";
    run_en = 1'b0;
    repeat (40) begin
      @(negedge clk);
      chk("R5", e_code, 29);
      chk("R5", r_code, 14);
    end
    run_en = 1'b1;

    // R3: select change mid period takes effect at the next reload
    tag = "R3";
    rate_sel = 2'd0;
    do_reset();
    repeat (5) @(negedge clk);
    rate_sel = 2'd3;
    repeat (60) @(negedge clk);

    // random enable and select traffic against the model
    tag = "R4";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      run_en = ($urandom % 8) != 0;
      if (($urandom % 40) == 0) rate_sel = 2'($urandom % 4);
      if (($urandom % 900) == 0) do_reset();
    end

    chk_on = 1'b0;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule